// File: doc/BRIEF.md
# PLL Reconfiguration Command Batcher

This block is a write-only management slave that stands between a configuration master and the settings of a clock synthesizer. The master issues single-cycle address/data writes. Each non-zero address is held in a small ordered buffer and has no effect yet. A write to address zero commits the batch. The block then raises its wait line and moves the held commands, oldest first, into shadow registers. There are three register groups: output and feedback divider counters, the bandwidth pair (charge-pump current and loop-filter setting), and a phase-step word.

Once the buffer is empty, a fixed busy interval models the synthesizer relocking. After that interval the wait line drops and the master may send the next batch. If the master sends more commands than the buffer can hold, the excess is dropped and a sticky overflow flag is raised. The next commit clears the flag.

Top module: `pllcfg_batch`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, waitreq_o and ovf_o are 0 and every shadow output (cnt_o, cp_o, lf_o, phase_o) reads zero.
- R2: A write with a non-zero address accepted while waitreq_o is low is queued and leaves every shadow output unchanged until a commit.
- R3: With DEPTH (8) commands queued, each further non-zero write is dropped. The first such write sets ovf_o in the next cycle, and ovf_o stays set until a commit.
- R4: A write to address 9'h000, with any data, accepted while waitreq_o is low raises waitreq_o in the next cycle. With N commands queued, waitreq_o stays high for exactly N+1+BUSY_CYC cycles and then falls.
- R5: Queued commands are applied in arrival order, so a later write to the same address overrides an earlier one.
- R6: Address decode uses bits [8:7] as the group and bits [6:0] as the index. Group 01 with index g < NUM_CNT (8) writes counter g. Group 10 with index 0 writes the charge-pump word, and index 1 writes the loop-filter word. Group 11 with index 0 writes the phase-step word. Any other non-zero address is queued but changes nothing when drained.
- R7: Every write, including a start write, that arrives while waitreq_o is high is ignored: it is neither queued nor starts a second commit.
- R8: A commit clears ovf_o in the cycle after the start write.
- R9: A commit with an empty buffer still holds waitreq_o high for BUSY_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 9 | Command address; zero means commit |
| wdata_i | input | DW | Command data |
| waitreq_o | output | 1 | High from the cycle after a commit until the busy interval ends |
| ovf_o | output | 1 | Sticky buffer overflow flag |
| cnt_o | output | NUM_CNT*DW | Divider counter shadow registers, counter g at [g] |
| cp_o | output | DW | Charge-pump shadow register |
| lf_o | output | DW | Loop-filter shadow register |
| phase_o | output | DW | Phase-step shadow register |

## Verification
The properties assume that wr_i is a clean one-cycle pulse and that addr_i is known whenever wr_i is high. The stimulus meets this by driving wr_i, addr_i and wdata_i only at falling edges and always returning wr_i to zero for at least one cycle between commands. The properties also assume the master never depends on a write made while waitreq_o is high. The bench makes such writes on purpose, only to show that they are discarded, and never depends on their effect.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
  localparam int ADDR_W = 9;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_CNT   = 2'd1,
    GRP_BW    = 2'd2,
    GRP_PHASE = 2'd3
  } grp_e;

  function automatic grp_e grp_of(input logic [ADDR_W-1:0] a);
    grp_e g;
    case (a[8:7])
      2'b01:   g = GRP_CNT;
      2'b10:   g = GRP_BW;
      2'b11:   g = GRP_PHASE;
      default: g = GRP_NONE;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/pllcfg_fifo.sv
module pllcfg_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 41
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wp_q] <= data_i;
  end

  // push and pop never coincide: the controller only pushes while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && !full_o) begin
        wp_q  <= inc_ptr(wp_q);
        cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && !empty_o) begin
        rp_q  <= inc_ptr(rp_q);
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pllcfg_ctrl.sv
module pllcfg_ctrl #(
  parameter int BUSY_CYC = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [pllcfg_pkg::ADDR_W-1:0] addr_i,
  input  logic                          full_i,
  input  logic                          empty_i,
  output logic                          push_o,
  output logic                          pop_o,
  output logic                          busy_o,
  output logic                          ovf_o
);
  localparam int HW = $clog2(BUSY_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_HOLD} st_e;

  st_e           st_q;
  logic [HW-1:0] hold_q;
  logic          ovf_q;
  logic          idle, start, cmd;

  assign idle   = (st_q == ST_IDLE);
  assign start  = idle && wr_i && (addr_i == '0);
  assign cmd    = idle && wr_i && (addr_i != '0);
  assign push_o = cmd && !full_i;
  assign pop_o  = (st_q == ST_DRAIN) && !empty_i;
  assign busy_o = !idle;
  assign ovf_o  = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (start)               ovf_q <= 1'b0;
      else if (cmd && full_i)  ovf_q <= 1'b1;
      unique case (st_q)
        ST_IDLE:  if (start) st_q <= ST_DRAIN;
        ST_DRAIN: if (empty_i) begin
          st_q   <= ST_HOLD;
          hold_q <= HW'(BUSY_CYC - 1);
        end
        ST_HOLD: begin
          if (hold_q == '0) st_q <= ST_IDLE;
          else              hold_q <= hold_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pllcfg_shadow.sv
module pllcfg_shadow
  import pllcfg_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int DW      = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               data_i,
  output logic [NUM_CNT-1:0][DW-1:0]  cnt_o,
  output logic [DW-1:0]               cp_o,
  output logic [DW-1:0]               lf_o,
  output logic [DW-1:0]               phase_o
);
  grp_e       grp;
  logic [6:0] idx;

  assign grp = grp_of(addr_i);
  assign idx = addr_i[6:0];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      r_q <= '0;
      else if (we_i && grp == GRP_CNT && idx == 7'(g))  r_q <= data_i;
    end
    assign cnt_o[g] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cp_o    <= '0;
      lf_o    <= '0;
      phase_o <= '0;
    end else if (we_i) begin
      if (grp == GRP_BW && idx == 7'd0)    cp_o    <= data_i;
      if (grp == GRP_BW && idx == 7'd1)    lf_o    <= data_i;
      if (grp == GRP_PHASE && idx == 7'd0) phase_o <= data_i;
    end
  end
endmodule

// File: rtl/pllcfg_batch.sv
module pllcfg_batch
  import pllcfg_pkg::*;
#(
  parameter int NUM_CNT  = 8,
  parameter int DW       = 32,
  parameter int DEPTH    = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic                        waitreq_o,
  output logic                        ovf_o,
  output logic [NUM_CNT-1:0][DW-1:0]  cnt_o,
  output logic [DW-1:0]               cp_o,
  output logic [DW-1:0]               lf_o,
  output logic [DW-1:0]               phase_o
);
  localparam int EW = ADDR_W + DW;

  logic          push, pop, full, empty;
  logic [EW-1:0] head;

  pllcfg_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i,
    .full_i(full), .empty_i(empty),
    .push_o(push), .pop_o(pop), .busy_o(waitreq_o), .ovf_o(ovf_o)
  );

  pllcfg_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .data_i({addr_i, wdata_i}),
    .pop_i(pop), .data_o(head), .full_o(full), .empty_o(empty)
  );

  pllcfg_shadow #(.NUM_CNT(NUM_CNT), .DW(DW)) u_shadow (
    .clk_i, .rst_ni,
    .we_i(pop), .addr_i(head[EW-1:DW]), .data_i(head[DW-1:0]),
    .cnt_o, .cp_o, .lf_o, .phase_o
  );
endmodule

// File: rtl/pllcfg_batch_chk.sv
module pllcfg_batch_chk #(
  parameter int NUM_CNT = 8,
  parameter int DW      = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_i,
  input logic [8:0]                 addr_i,
  input logic                       waitreq_o,
  input logic                       ovf_o,
  input logic [NUM_CNT-1:0][DW-1:0] cnt_o,
  input logic [DW-1:0]              cp_o,
  input logic [DW-1:0]              lf_o,
  input logic [DW-1:0]              phase_o
);
  logic commit;
  assign commit = !waitreq_o && wr_i && (addr_i == 9'd0);

  a_r4_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> waitreq_o);

  a_r4_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(waitreq_o) |-> $past(commit));

  a_r8_ovf_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !ovf_o);

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !commit) |=> ovf_o);

  a_r3_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(wr_i && !waitreq_o && addr_i != 9'd0));

  a_r2_shadow_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !waitreq_o |=> ($stable(cnt_o) && $stable(cp_o) && $stable(lf_o) && $stable(phase_o)));
endmodule

bind pllcfg_batch pllcfg_batch_chk #(.NUM_CNT(NUM_CNT), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .waitreq_o(waitreq_o), .ovf_o(ovf_o), .cnt_o(cnt_o),
  .cp_o(cp_o), .lf_o(lf_o), .phase_o(phase_o)
);

// File: tb/pllcfg_batch_tb.sv
module pllcfg_batch_tb;
  localparam int NUM_CNT = 8, DW = 32, DEPTH = 8, BUSY = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0;
  logic [8:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic waitreq_o, ovf_o;
  logic [NUM_CNT-1:0][DW-1:0] cnt_o;
  logic [DW-1:0] cp_o, lf_o, phase_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  pllcfg_batch #(.NUM_CNT(NUM_CNT), .DW(DW), .DEPTH(DEPTH), .BUSY_CYC(BUSY)) u_dut (.*);

  // {addr, data}; group 01 = counter, 10 = bandwidth, 11 = phase
  localparam logic [40:0] VEC [8] = '{
    {9'h080, 32'h0000_0F0F}, {9'h081, 32'h0001_0000},
    {9'h082, 32'h0000_0303}, {9'h085, 32'h0000_1E1E},
    {9'h087, 32'h0000_2625}, {9'h100, 32'h0000_0010},
    {9'h101, 32'h0000_0100}, {9'h180, 32'h0000_0042}
  };

  function automatic logic [DW-1:0] shadow_at(input logic [8:0] a);
    case (a[8:7])
      2'b01:   return cnt_o[a[2:0]];
      2'b10:   return a[0] ? lf_o : cp_o;
      default: return phase_o;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [8:0] a, input logic [DW-1:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (waitreq_o) begin n++; @(negedge clk_i); end
  endtask

  task automatic commit(output int n, output logic ovf_after);
    wr_cmd(9'h000, 32'hFFFF_FFFF);
    ovf_after = ovf_o;
    wait_idle(n);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic ov;
    logic [NUM_CNT-1:0][DW-1:0] snap_cnt;
    logic [DW-1:0] snap_cp, snap_lf, snap_ph;

    repeat (3) @(negedge clk_i);
    chk(!waitreq_o && !ovf_o, "R1 flags in reset", {waitreq_o, ovf_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!waitreq_o && !ovf_o, "R1 flags after reset", {waitreq_o, ovf_o}, 0);
    chk(cnt_o == '0 && cp_o == 0 && lf_o == 0 && phase_o == 0, "R1 shadows zero", cp_o | lf_o | phase_o, 0);

    // table walk: queue all, nothing visible, then commit
    foreach (VEC[i]) wr_cmd(VEC[i][40:32], VEC[i][31:0]);
    for (int i = 0; i < 8; i++) chk(shadow_at(VEC[i][40:32]) == 0, "R2 held until commit", shadow_at(VEC[i][40:32]), 0);
    commit(n, ov);
    chk(n == 8 + 1 + BUSY, "R4 busy length full batch", n, 8 + 1 + BUSY);
    for (int i = 0; i < 8; i++)
      chk(shadow_at(VEC[i][40:32]) == VEC[i][31:0], "R6 decode table", shadow_at(VEC[i][40:32]), VEC[i][31:0]);

    // R5 order: later write to same address wins
    wr_cmd(9'h083, 32'hAAAA);
    wr_cmd(9'h083, 32'hBBBB);
    commit(n, ov);
    chk(cnt_o[3] == 32'hBBBB, "R5 arrival order", cnt_o[3], 32'hBBBB);
    chk(n == 2 + 1 + BUSY, "R4 busy length two", n, 2 + 1 + BUSY);

    // R6 unmapped addresses drain without effect
    snap_cnt = cnt_o; snap_cp = cp_o; snap_lf = lf_o; snap_ph = phase_o;
    wr_cmd(9'h005, 32'h1); wr_cmd(9'h088, 32'h2); wr_cmd(9'h102, 32'h3); wr_cmd(9'h181, 32'h4);
    commit(n, ov);
    chk(n == 4 + 1 + BUSY, "R6 unmapped still queued", n, 4 + 1 + BUSY);
    chk(cnt_o == snap_cnt && cp_o == snap_cp && lf_o == snap_lf && phase_o == snap_ph,
        "R6 unmapped no effect", phase_o, snap_ph);

    // R9 empty commit
    commit(n, ov);
    chk(n == BUSY + 1, "R9 empty busy pulse", n, BUSY + 1);

    // R7 writes during busy ignored
    wr_cmd(9'h081, 32'h1111);
    wr_cmd(9'h000, 32'h0);
    chk(waitreq_o, "R4 busy raised", waitreq_o, 1);
    wr_cmd(9'h081, 32'h2222);
    wr_cmd(9'h000, 32'h0);
    wait_idle(n);
    chk(cnt_o[1] == 32'h1111, "R7 busy write ignored", cnt_o[1], 32'h1111);
    commit(n, ov);
    chk(n == BUSY + 1, "R7 nothing queued while busy", n, BUSY + 1);
    chk(cnt_o[1] == 32'h1111, "R7 value kept", cnt_o[1], 32'h1111);

    // R3 overflow, R8 clear
    for (int i = 0; i < DEPTH; i++) wr_cmd(9'h100, 32'(i));
    chk(!ovf_o, "R3 no flag at depth", ovf_o, 0);
    wr_cmd(9'h180, 32'hDEAD);
    chk(ovf_o, "R3 flag on extra", ovf_o, 1);
    wr_cmd(9'h101, 32'hBEEF);
    chk(ovf_o, "R3 flag sticky", ovf_o, 1);
    commit(n, ov);
    chk(!ov, "R8 cleared by commit", ov, 0);
    chk(n == DEPTH + 1 + BUSY, "R3 only depth queued", n, DEPTH + 1 + BUSY);
    chk(phase_o == 32'h42, "R3 extra dropped", phase_o, 32'h42);
    chk(lf_o == 32'h100, "R3 later extra dropped", lf_o, 32'h100);
    chk(cp_o == 32'(DEPTH - 1), "R5 last of batch", cp_o, 32'(DEPTH - 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule